// File: doc/BRIEF.md
# Dual-Channel Storage Interrupt Aggregator

This block collects the interrupt requests of two disk channels and turns them into one level-sensitive interrupt line for the host bus. Each channel owns one interrupt flag, and that flag is visible in two places of configuration space: in a shared status byte, which also carries the per-channel block bits, and in a per-channel mirror byte. Both copies are stored and kept equal whichever of them is written.

A drive-side request changing level moves the channel's flag to the new level. Host software clears a flag by writing a one to it through the configuration write port, at either of its two locations. The block bits, which keep a channel's flag off the shared line, are written directly through a side port that the bus-master register window drives. A configuration write carries up to four bytes at consecutive addresses, handled from the lowest address up. The output level is settled once per write.

Top module: `dci_irq_agg`

## Requirements
- R1: After reset every flag and block bit is 0, `irq` is low and reads of 0x50, 0x57 and 0x71 return 0.
- R2: A change of level on `drv_irq[n]` sampled at a clock edge makes channel n's flag equal the new level after that edge. The flag reads as bit (2+n) of 0x71. Channel 0's copy is bit 2 of 0x50 and channel 1's copy is bit 4 of 0x57.
- R3: `irq` is high exactly when some channel has its flag set and its block bit clear. It changes on the same edge as the state that causes the change.
- R4: A configuration write to 0x71 with a 1 in bit 2 or bit 3 clears the flag of channel 0 or channel 1 in both copies. A 0 in those bits leaves the flag unchanged.
- R5: A configuration write of 1 to bit 2 of 0x50 clears channel 0's flag in both copies. A configuration write of 1 to bit 4 of 0x57 does the same for channel 1.
- R6: The configuration port can never set a flag and never changes a block bit. Writing 0xFF to 0x71 leaves bits 4 and 5 as they were.
- R7: A configuration write carries `cfg_wr_len`+1 bytes. Byte i sits in `cfg_wr_data[8i+7:8i]` and goes to address `cfg_wr_addr`+i. Bytes beyond the length have no effect.
- R8: A side-port write loads the block bits directly: channel 0 is bit 0 of `blk_wr_data` and reads as bit 4 of 0x71, channel 1 is bit 1 and reads as bit 5. The write both sets and clears.
- R9: When a drive-side level change and a clearing configuration write hit the same flag in one cycle, the flag takes the drive level.
- R10: A request held steady does not set its flag again after software has cleared it. Only a change of level moves the flag.
- R11: Reads at any other offset return 0, and unused bits of 0x50, 0x57 and 0x71 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| drv_irq | input | 2 | Drive-side interrupt request level per channel |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_addr | input | 8 | Byte address of the first byte written |
| cfg_wr_len | input | 2 | Number of bytes written minus one |
| cfg_wr_data | input | 32 | Write bytes, lowest address in the low byte |
| blk_wr_en | input | 1 | Side-port block-bit write strobe |
| blk_wr_data | input | 2 | New block bits, one per channel |
| cfg_rd_addr | input | 8 | Configuration read byte address |
| cfg_rd_data | output | 8 | Configuration read data |
| irq | output | 1 | Combined interrupt level |

## Verification
The two stored copies of a flag can drift apart. That shows at once as a disagreement between 0x71 and the mirror byte, read right after the edge that caused it. A flag that is wrong, or a block bit that is wrong, reaches `irq` within the same cycle. So every scenario reads both copies and samples the line after each single stimulus edge. The race case and the held-request case are checked at the edge where they happen, because a wrong priority is only visible there and is overwritten by later traffic.

// File: rtl/dci_pkg.sv
package dci_pkg;
   // the aggregator serves a fixed pair of channels
   localparam int unsigned CH_NUM = 2;
   localparam int unsigned BYTE_W = 8;

   typedef logic [CH_NUM-1:0] ch_vec_t;
endpackage

// File: rtl/dci_req_edge.sv
module dci_req_edge #(
   parameter int unsigned NUM_CH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   output logic [NUM_CH-1:0] chg_o
);
   logic [NUM_CH-1:0] prev_q;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[c] <= 1'b0;
         else        prev_q[c] <= req_i[c];
      end
      assign chg_o[c] = req_i[c] ^ prev_q[c];
   end
endmodule

// File: rtl/dci_cfg_seq.sv
module dci_cfg_seq #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned MAX_BYTES     = 4,
   parameter int unsigned MAIN_OFF      = 8'h71,
   parameter int unsigned MAIN_FLAG_LSB = 2,
   parameter int unsigned MIR0_OFF      = 8'h50,
   parameter int unsigned MIR0_BIT      = 2,
   parameter int unsigned MIR1_OFF      = 8'h57,
   parameter int unsigned MIR1_BIT      = 4,
   localparam int unsigned LEN_W        = $clog2(MAX_BYTES),
   localparam int unsigned DATA_W       = 8 * MAX_BYTES
) (
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [LEN_W-1:0]    wr_len,
   input  logic [DATA_W-1:0]   wr_data,
   input  dci_pkg::ch_vec_t    main_i,
   input  dci_pkg::ch_vec_t    mir_i,
   output dci_pkg::ch_vec_t    main_o,
   output dci_pkg::ch_vec_t    mir_o
);
   localparam int unsigned AW = ADDR_W + 1;

   logic [AW-1:0]    byte_addr;
   logic [7:0]       byte_val;
   dci_pkg::ch_vec_t main_v;
   dci_pkg::ch_vec_t mir_v;

   // bytes are walked from the lowest address up; every hit resyncs the copies
   always_comb begin
      main_v    = main_i;
      mir_v     = mir_i;
      byte_addr = '0;
      byte_val  = '0;
      if (wr_en) begin
         for (int i = 0; i < int'(MAX_BYTES); i++) begin
            if (i <= int'(wr_len)) begin
               byte_addr = {1'b0, wr_addr} + AW'(i);
               byte_val  = wr_data[8*i +: 8];
               if (byte_addr == AW'(MIR0_OFF)) begin
                  if (byte_val[MIR0_BIT]) mir_v[0] = 1'b0;
                  main_v = mir_v;
               end else if (byte_addr == AW'(MIR1_OFF)) begin
                  if (byte_val[MIR1_BIT]) mir_v[1] = 1'b0;
                  main_v = mir_v;
               end else if (byte_addr == AW'(MAIN_OFF)) begin
                  for (int c = 0; c < int'(dci_pkg::CH_NUM); c++) begin
                     if (byte_val[MAIN_FLAG_LSB + c]) main_v[c] = 1'b0;
                  end
                  mir_v = main_v;
               end
            end
         end
      end
   end

   assign main_o = main_v;
   assign mir_o  = mir_v;
endmodule

// File: rtl/dci_irq_gate.sv
module dci_irq_gate #(
   parameter int unsigned NUM_CH  = 2,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] flag_i,
   input  logic [NUM_CH-1:0] blk_i,
   output logic              irq_o
);
   logic lvl;

   assign lvl = |(flag_i & ~blk_i);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= lvl;
      end
      assign irq_o = irq_q;
   end else begin : g_comb
      assign irq_o = lvl;
   end
endmodule

// File: rtl/dci_irq_agg.sv
module dci_irq_agg #(
   parameter int unsigned ADDR_W        = 8,
   parameter int unsigned MAX_BYTES     = 4,
   parameter int unsigned MAIN_OFF      = 8'h71,
   parameter int unsigned MAIN_FLAG_LSB = 2,
   parameter int unsigned MAIN_BLK_LSB  = 4,
   parameter int unsigned MIR0_OFF      = 8'h50,
   parameter int unsigned MIR0_BIT      = 2,
   parameter int unsigned MIR1_OFF      = 8'h57,
   parameter int unsigned MIR1_BIT      = 4,
   parameter bit          REG_OUT       = 1'b1,
   localparam int unsigned NUM_CH       = dci_pkg::CH_NUM,
   localparam int unsigned LEN_W        = $clog2(MAX_BYTES),
   localparam int unsigned DATA_W       = 8 * MAX_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] drv_irq,
   input  logic              cfg_wr_en,
   input  logic [ADDR_W-1:0] cfg_wr_addr,
   input  logic [LEN_W-1:0]  cfg_wr_len,
   input  logic [DATA_W-1:0] cfg_wr_data,
   input  logic              blk_wr_en,
   input  logic [NUM_CH-1:0] blk_wr_data,
   input  logic [ADDR_W-1:0] cfg_rd_addr,
   output logic [7:0]        cfg_rd_data,
   output logic              irq
);
   // elaboration-time parameter checks
   if (MAX_BYTES < 2 || MAX_BYTES > 8) begin : g_bad_bytes
      $error("MAX_BYTES must lie in 2..8");
   end
   if (MAIN_FLAG_LSB + NUM_CH > 8 || MAIN_BLK_LSB + NUM_CH > 8) begin : g_bad_main
      $error("status byte fields exceed eight bits");
   end
   if (MAIN_BLK_LSB < MAIN_FLAG_LSB + NUM_CH && MAIN_FLAG_LSB < MAIN_BLK_LSB + NUM_CH) begin : g_overlap
      $error("flag and block fields overlap");
   end
   if (MIR0_BIT > 7 || MIR1_BIT > 7) begin : g_bad_mir
      $error("mirror bit out of byte");
   end
   if (MIR0_OFF == MIR1_OFF || MIR0_OFF == MAIN_OFF || MIR1_OFF == MAIN_OFF) begin : g_bad_off
      $error("register offsets must differ");
   end
   if (MAIN_OFF >= (1 << ADDR_W) || MIR0_OFF >= (1 << ADDR_W) || MIR1_OFF >= (1 << ADDR_W)) begin : g_bad_aw
      $error("offset beyond address width");
   end

   dci_pkg::ch_vec_t main_q, mir_q, blk_q;
   dci_pkg::ch_vec_t main_w, mir_w;
   dci_pkg::ch_vec_t main_n, mir_n, blk_n;
   dci_pkg::ch_vec_t req_chg;
   dci_pkg::ch_vec_t gate_flag, gate_blk;

   dci_req_edge #(.NUM_CH(NUM_CH)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .req_i (drv_irq),
      .chg_o (req_chg)
   );

   dci_cfg_seq #(
      .ADDR_W        (ADDR_W),
      .MAX_BYTES     (MAX_BYTES),
      .MAIN_OFF      (MAIN_OFF),
      .MAIN_FLAG_LSB (MAIN_FLAG_LSB),
      .MIR0_OFF      (MIR0_OFF),
      .MIR0_BIT      (MIR0_BIT),
      .MIR1_OFF      (MIR1_OFF),
      .MIR1_BIT      (MIR1_BIT)
   ) u_seq (
      .wr_en   (cfg_wr_en),
      .wr_addr (cfg_wr_addr),
      .wr_len  (cfg_wr_len),
      .wr_data (cfg_wr_data),
      .main_i  (main_q),
      .mir_i   (mir_q),
      .main_o  (main_w),
      .mir_o   (mir_w)
   );

   // a drive-side level change overrides the result of the write sequence
   always_comb begin
      main_n = main_w;
      mir_n  = mir_w;
      for (int c = 0; c < int'(NUM_CH); c++) begin
         if (req_chg[c]) begin
            main_n[c] = drv_irq[c];
            mir_n[c]  = drv_irq[c];
         end
      end
      blk_n = blk_wr_en ? blk_wr_data : blk_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_q <= '0;
         mir_q  <= '0;
         blk_q  <= '0;
      end else begin
         main_q <= main_n;
         mir_q  <= mir_n;
         blk_q  <= blk_n;
      end
   end

   // registered output looks at next state, combinational output at current
   assign gate_flag = REG_OUT ? main_n : main_q;
   assign gate_blk  = REG_OUT ? blk_n  : blk_q;

   dci_irq_gate #(.NUM_CH(NUM_CH), .REG_OUT(REG_OUT)) u_gate (
      .clk    (clk),
      .rst_n  (rst_n),
      .flag_i (gate_flag),
      .blk_i  (gate_blk),
      .irq_o  (irq)
   );

   always_comb begin
      cfg_rd_data = '0;
      if (cfg_rd_addr == ADDR_W'(MIR0_OFF)) begin
         cfg_rd_data[MIR0_BIT] = mir_q[0];
      end else if (cfg_rd_addr == ADDR_W'(MIR1_OFF)) begin
         cfg_rd_data[MIR1_BIT] = mir_q[1];
      end else if (cfg_rd_addr == ADDR_W'(MAIN_OFF)) begin
         for (int c = 0; c < int'(NUM_CH); c++) begin
            cfg_rd_data[MAIN_FLAG_LSB + c] = main_q[c];
            cfg_rd_data[MAIN_BLK_LSB + c]  = blk_q[c];
         end
      end
   end
endmodule

// File: rtl/dci_irq_agg_chk.sv
module dci_irq_agg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] drv_irq,
   input logic       blk_wr_en,
   input logic [1:0] blk_wr_data,
   input logic       irq,
   input logic [1:0] main_q,
   input logic [1:0] mir_q,
   input logic [1:0] blk_q,
   input logic [1:0] req_chg
);
   AST_MIRROR_COHERENT: assert property (@(posedge clk) disable iff (!rst_n)
      main_q == mir_q); // R5

   AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      irq == |(main_q & ~blk_q)); // R3

   AST_CH0_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_chg[0] |=> main_q[0] == $past(drv_irq[0])); // R9

   AST_CH1_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_chg[1] |=> main_q[1] == $past(drv_irq[1])); // R2

   AST_CH0_NO_CFG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_q[0]) |-> $past(req_chg[0])); // R6

   AST_CH1_NO_CFG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_q[1]) |-> $past(req_chg[1])); // R10

   AST_BLK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      blk_wr_en |=> blk_q == $past(blk_wr_data)); // R8

   AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !blk_wr_en |=> $stable(blk_q)); // R6
endmodule

bind dci_irq_agg dci_irq_agg_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .drv_irq     (drv_irq),
   .blk_wr_en   (blk_wr_en),
   .blk_wr_data (blk_wr_data),
   .irq         (irq),
   .main_q      (main_q),
   .mir_q       (mir_q),
   .blk_q       (blk_q),
   .req_chg     (req_chg)
);

// File: tb/dci_irq_agg_tb_top.sv
`timescale 1ns/1ps
module dci_irq_agg_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  drv_irq = '0;
   logic        cfg_wr_en = 1'b0;
   logic [7:0]  cfg_wr_addr = '0;
   logic [1:0]  cfg_wr_len = '0;
   logic [31:0] cfg_wr_data = '0;
   logic        blk_wr_en = 1'b0;
   logic [1:0]  blk_wr_data = '0;
   logic [7:0]  cfg_rd_addr = '0;
   logic [7:0]  cfg_rd_data;
   logic        irq;

   int n_total = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   dci_irq_agg dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .drv_irq     (drv_irq),
      .cfg_wr_en   (cfg_wr_en),
      .cfg_wr_addr (cfg_wr_addr),
      .cfg_wr_len  (cfg_wr_len),
      .cfg_wr_data (cfg_wr_data),
      .blk_wr_en   (blk_wr_en),
      .blk_wr_data (blk_wr_data),
      .cfg_rd_addr (cfg_rd_addr),
      .cfg_rd_data (cfg_rd_data),
      .irq         (irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic check_rd(input logic [7:0] addr, input logic [7:0] exp, input string req);
      cfg_rd_addr = addr;
      #1;
      check(cfg_rd_data == exp, req, int'(cfg_rd_data), int'(exp));
   endtask

   task automatic check_irq(input logic exp, input string req);
      check(irq == exp, req, int'(irq), int'(exp));
   endtask

   task automatic cfg_write(input logic [7:0] addr, input logic [1:0] len, input logic [31:0] data);
      cfg_wr_en = 1'b1; cfg_wr_addr = addr; cfg_wr_len = len; cfg_wr_data = data;
      tick();
      cfg_wr_en = 1'b0;
   endtask

   task automatic blk_write(input logic [1:0] val);
      blk_wr_en = 1'b1; blk_wr_data = val;
      tick();
      blk_wr_en = 1'b0;
   endtask

   task automatic set_req(input logic [1:0] val);
      drv_irq = val;
      tick();
   endtask

   task automatic t_reset();
      check_irq(1'b0, "R1 irq after reset");
      check_rd(8'h71, 8'h00, "R1 status byte");
      check_rd(8'h50, 8'h00, "R1 mirror 0");
      check_rd(8'h57, 8'h00, "R1 mirror 1");
   endtask

   task automatic t_drive();
      set_req(2'b01);
      check_rd(8'h71, 8'h04, "R2 ch0 set status");
      check_rd(8'h50, 8'h04, "R2 ch0 set mirror");
      check_irq(1'b1, "R3 ch0 raises line");
      set_req(2'b11);
      check_rd(8'h71, 8'h0C, "R2 both set status");
      check_rd(8'h57, 8'h10, "R2 ch1 set mirror");
      set_req(2'b10);
      check_rd(8'h71, 8'h08, "R2 ch0 cleared by level");
      check_rd(8'h50, 8'h00, "R2 ch0 mirror cleared");
      check_irq(1'b1, "R3 ch1 keeps line");
      set_req(2'b00);
      check_rd(8'h71, 8'h00, "R2 all cleared");
      check_irq(1'b0, "R3 line drops");
   endtask

   task automatic t_w1c_main();
      set_req(2'b11);
      cfg_write(8'h71, 2'd0, 32'h0000_0000);
      check_rd(8'h71, 8'h0C, "R4 zero write keeps flags");
      cfg_write(8'h71, 2'd0, 32'h0000_0004);
      check_rd(8'h71, 8'h08, "R4 clear ch0");
      check_rd(8'h50, 8'h00, "R4 ch0 mirror follows");
      check_irq(1'b1, "R3 ch1 still pending");
      cfg_write(8'h71, 2'd0, 32'h0000_00FB);
      check_rd(8'h71, 8'h00, "R6 block bits not writable by cfg");
      check_rd(8'h57, 8'h00, "R4 ch1 mirror follows");
      check_irq(1'b0, "R3 line low after clears");
      tick();
      check_rd(8'h71, 8'h00, "R10 held request does not reset flag");
      set_req(2'b00);
   endtask

   task automatic t_w1c_mirror();
      set_req(2'b11);
      cfg_write(8'h57, 2'd0, 32'h0000_00EF);
      check_rd(8'h71, 8'h0C, "R5 zero in mirror bit keeps flag");
      cfg_write(8'h57, 2'd0, 32'h0000_0010);
      check_rd(8'h71, 8'h04, "R5 clear ch1 via mirror");
      check_rd(8'h57, 8'h00, "R5 ch1 mirror cleared");
      cfg_write(8'h50, 2'd0, 32'h0000_0004);
      check_rd(8'h71, 8'h00, "R5 clear ch0 via mirror");
      check_irq(1'b0, "R5 line low");
      set_req(2'b00);
   endtask

   task automatic t_multi();
      set_req(2'b11);
      cfg_write(8'h70, 2'd0, 32'h0000_0800);
      check_rd(8'h71, 8'h0C, "R7 byte beyond length ignored");
      cfg_write(8'h72, 2'd3, 32'hFFFF_FFFF);
      check_rd(8'h71, 8'h0C, "R7 write above register ignored");
      cfg_write(8'h70, 2'd3, 32'h0000_0800);
      check_rd(8'h71, 8'h04, "R7 byte lane 1 reaches 0x71");
      cfg_write(8'h4E, 2'd3, 32'h0004_0000);
      check_rd(8'h71, 8'h00, "R7 byte lane 2 reaches 0x50");
      check_irq(1'b0, "R7 line low");
      set_req(2'b00);
   endtask

   task automatic t_block();
      set_req(2'b01);
      check_irq(1'b1, "R3 ch0 unblocked");
      blk_write(2'b01);
      check_irq(1'b0, "R8 ch0 blocked");
      check_rd(8'h71, 8'h14, "R8 block readback ch0");
      blk_write(2'b10);
      check_irq(1'b1, "R8 block cleared by side port");
      check_rd(8'h71, 8'h24, "R8 block readback ch1");
      set_req(2'b11);
      check_irq(1'b1, "R3 ch0 passes with ch1 blocked");
      blk_write(2'b11);
      check_irq(1'b0, "R3 both blocked");
      check_rd(8'h71, 8'h3C, "R8 full readback");
      cfg_write(8'h71, 2'd0, 32'h0000_0030);
      check_rd(8'h71, 8'h3C, "R6 cfg write leaves block bits");
      blk_write(2'b00);
      check_irq(1'b1, "R3 unblocked again");
      set_req(2'b00);
      check_irq(1'b0, "R3 line low at end");
   endtask

   task automatic t_race();
      drv_irq = 2'b01;
      cfg_wr_en = 1'b1; cfg_wr_addr = 8'h71; cfg_wr_len = 2'd0; cfg_wr_data = 32'h0000_0004;
      tick();
      cfg_wr_en = 1'b0;
      check_rd(8'h71, 8'h04, "R9 drive change beats clear");
      check_irq(1'b1, "R9 line high");
      set_req(2'b00);
   endtask

   task automatic t_other();
      set_req(2'b11);
      cfg_write(8'h51, 2'd0, 32'h0000_00FF);
      check_rd(8'h71, 8'h0C, "R11 write to other offset ignored");
      check_rd(8'h60, 8'h00, "R11 other offset reads zero");
      check_rd(8'h50, 8'h04, "R11 unused mirror bits zero");
      check_rd(8'h57, 8'h10, "R11 unused mirror bits zero ch1");
      set_req(2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      tick();
      t_reset();
      t_drive();
      t_w1c_main();
      t_w1c_mirror();
      t_multi();
      t_block();
      t_race();
      t_other();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      #200us;
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end
endmodule